// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This unit keeps the floating-point state that software and the floating-point datapath share in a scalar core: five sticky exception flags and a three-bit dynamic rounding mode. Software reaches that state through a CSR port. The port decodes a 12-bit address and carries replace, set-bits and clear-bits operations. The datapath reports the exception conditions of completing operations on an accrual port. Raising a flag never traps. Software must read the flags to learn of an exception.

The unit also resolves the rounding mode for the instruction in flight. It takes the instruction's 3-bit rounding field and returns the mode that applies. Alongside that mode it returns an indication that the mode is reserved, which the decoder uses to mark the instruction illegal. It does this for every instruction that carries the field, whether or not the result depends on rounding.

The accrual port is a one-way stream. A beat is taken on every clock edge where `acc_valid` is high. There is no ready and no back-pressure: the unit always accepts. All other pins are plain control and status signals. The unit has an asynchronous, active-low reset.

Top module: `fpu_csr_unit`

## Requirements
- R1: After reset, the flags and the rounding mode are all zero.
- R2: Address 0x001 reads the flags with invalid at bit 4, divide-by-zero at bit 3, overflow at bit 2, underflow at bit 1 and inexact at bit 0. All higher bits of `csr_rdata` read zero.
- R3: Address 0x002 reads the rounding mode in bits 2:0 and zero elsewhere. The mode encodings are: 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero.
- R4: Address 0x003 reads the rounding mode in bits 7:5 and the flags in bits 4:0. A write through it updates both from those bit positions.
- R5: Any other address gives `csr_hit` = 0 and `csr_rdata` = 0. An operation on such an address changes no state.
- R6: With `csr_en` high, `csr_op` 01 replaces the addressed fields with the write data, 10 ORs the write data in, and 11 clears the bits that are set in the write data. Op 00, or `csr_en` low, leaves the state unchanged. Write-data bits outside the addressed fields are ignored. Results are visible from the cycle after the edge.
- R7: On each edge where `acc_valid` is high, the bits of `acc_flags` (same bit layout as R2) are ORed into the flags. A flag is never cleared except by a CSR operation.
- R8: When a CSR operation and an accrual happen in the same cycle, the CSR result is formed first and the accrued bits are ORed on top. A flag raised in the same cycle as a software clear therefore stays set.
- R9: An `inst_rm` value from 000 to 100 is passed to `eff_rm` with `rm_bad` = 0. The values 101 and 110 pass through with `rm_bad` = 1.
- R10: An `inst_rm` of 111 selects the stored mode for `eff_rm`. `rm_bad` is 1 when the stored mode is 101, 110 or 111. The value 111 can be stored and reads back unchanged.
- R11: `csr_hit` is 1 exactly for the addresses 0x001, 0x002 and 0x003. `csr_rdata` and `csr_hit` follow the address combinationally, whatever the value of `csr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access enable; gates every state change from the CSR port |
| csr_op | input | 2 | 00 none, 01 replace, 10 set bits, 11 clear bits |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data or bit mask |
| csr_rdata | output | 32 | Current value at `csr_addr`, before this cycle's update |
| csr_hit | output | 1 | Address is one of the unit's registers |
| acc_valid | input | 1 | Datapath reports exception bits this cycle (always accepted) |
| acc_flags | input | 5 | Exception bits to accrue, layout as in R2 |
| inst_rm | input | 3 | Rounding field of the current instruction |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_bad | output | 1 | Resolved mode is reserved; instruction is illegal |

## Verification
Some properties are checked on every cycle. A flag never drops without a CSR access in the cycle before. Every accrued bit shows up in the flags one edge later. The mode is stable when the port is idle. Unmapped and flag-register reads show no stray bits. Static fields resolve correctly, and a 111 field resolves to the stored mode. Some behaviour can only be seen in the bench's scenarios, because it needs a reference model of the stored state: replace, set and clear arithmetic through each address, the layout of the combined register, writes that reach no register, and the same-cycle clear-versus-raise ordering.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 12'h001;
  localparam logic [ADDR_W-1:0] ADDR_RMODE = 12'h002;
  localparam logic [ADDR_W-1:0] ADDR_BOTH  = 12'h003;

  localparam logic [RM_W-1:0] RM_DYN       = 3'b111;
  localparam logic [RM_W-1:0] RM_MAX_LEGAL = 3'b100;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  // One bit of a CSR read-modify-write.
  function automatic logic op_bit(csr_op_e op, logic cur, logic din);
    case (op)
      OP_WRITE: return din;
      OP_SET:   return cur | din;
      OP_CLEAR: return cur & ~din;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import fpcsr_pkg::*;
#(
  parameter bit COMB_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_flags,
  output logic              sel_rm,
  output logic              sel_both,
  output logic              hit
);
  logic a_flags, a_rm, a_both;

  assign a_flags = (addr == ADDR_FLAGS);
  assign a_rm    = (addr == ADDR_RMODE);

  generate
    if (COMB_EN) begin : g_both
      assign a_both = (addr == ADDR_BOTH);
    end else begin : g_no_both
      assign a_both = 1'b0;
    end
  endgenerate

  assign sel_both  = a_both;
  assign sel_flags = a_flags | a_both;
  assign sel_rm    = a_rm | a_both;
  assign hit       = a_flags | a_rm | a_both;
endmodule

// File: rtl/fpcsr_flag_store.sv
module fpcsr_flag_store
  import fpcsr_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  csr_op_e      sw_op,
  input  logic [W-1:0] sw_data,
  input  logic         acc_valid,
  input  logic [W-1:0] acc_bits,
  output logic [W-1:0] flags_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic sw_val, nxt;
    // Software result first, datapath bits ORed on top.
    assign sw_val = sw_we ? op_bit(sw_op, flags_q[i], sw_data[i]) : flags_q[i];
    assign nxt    = sw_val | (acc_valid & acc_bits[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/fpcsr_rm_store.sv
module fpcsr_rm_store
  import fpcsr_pkg::*;
#(
  parameter int W = RM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  csr_op_e      sw_op,
  input  logic [W-1:0] sw_data,
  output logic [W-1:0] rm_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rm_q[i] <= 1'b0;
      else if (sw_we) rm_q[i] <= op_bit(sw_op, rm_q[i], sw_data[i]);
    end
  end
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
  import fpcsr_pkg::*;
(
  input  logic [RM_W-1:0] inst_rm,
  input  logic [RM_W-1:0] dyn_rm,
  output logic [RM_W-1:0] eff_rm,
  output logic            bad
);
  // A dynamic pick can land on 111; a static field never can.
  assign eff_rm = (inst_rm == RM_DYN) ? dyn_rm : inst_rm;
  assign bad    = (eff_rm > RM_MAX_LEGAL);
endmodule

// File: rtl/fpu_csr_unit.sv
module fpu_csr_unit
  import fpcsr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit COMB_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_hit,
  input  logic              acc_valid,
  input  logic [FLAG_W-1:0] acc_flags,
  input  logic [RM_W-1:0]   inst_rm,
  output logic [RM_W-1:0]   eff_rm,
  output logic              rm_bad
);
  localparam int BOTH_RM_LSB = FLAG_W;
  localparam int USED_W      = FLAG_W + RM_W;

  logic              sel_flags, sel_rm, sel_both;
  logic              active;
  csr_op_e           op;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic [RM_W-1:0]   rm_din;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^csr_wdata[XLEN-1:USED_W];

  assign op     = csr_op_e'(csr_op);
  assign active = csr_en && (op != OP_NONE);
  assign rm_din = sel_both ? csr_wdata[BOTH_RM_LSB +: RM_W] : csr_wdata[RM_W-1:0];

  fpcsr_decode #(.COMB_EN(COMB_EN)) u_dec (
    .addr      (csr_addr),
    .sel_flags (sel_flags),
    .sel_rm    (sel_rm),
    .sel_both  (sel_both),
    .hit       (csr_hit)
  );

  fpcsr_flag_store #(.W(FLAG_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (active && sel_flags),
    .sw_op     (op),
    .sw_data   (csr_wdata[FLAG_W-1:0]),
    .acc_valid (acc_valid),
    .acc_bits  (acc_flags),
    .flags_q   (flags_q)
  );

  fpcsr_rm_store #(.W(RM_W)) u_rm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (active && sel_rm),
    .sw_op   (op),
    .sw_data (rm_din),
    .rm_q    (rm_q)
  );

  fpcsr_rm_resolve u_res (
    .inst_rm (inst_rm),
    .dyn_rm  (rm_q),
    .eff_rm  (eff_rm),
    .bad     (rm_bad)
  );

  always_comb begin
    csr_rdata = '0;
    if (sel_flags) csr_rdata[FLAG_W-1:0] = flags_q;
    if (sel_both)  csr_rdata[BOTH_RM_LSB +: RM_W] = rm_q;
    else if (sel_rm) csr_rdata[RM_W-1:0] = rm_q;
  end
endmodule

// File: rtl/fpu_csr_unit_chk.sv
module fpu_csr_unit_chk
  import fpcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_hit,
  input logic              acc_valid,
  input logic [FLAG_W-1:0] acc_flags,
  input logic [RM_W-1:0]   inst_rm,
  input logic [RM_W-1:0]   eff_rm,
  input logic              rm_bad,
  input logic [FLAG_W-1:0] flags_q,
  input logic [RM_W-1:0]   rm_q
);
  // R7
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_en) |-> (($past(flags_q) & ~flags_q) == '0));

  // R7
  flags_accrue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(acc_valid)) |-> ((flags_q & $past(acc_flags)) == $past(acc_flags)));

  // R6
  rm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_en) |-> (rm_q == $past(rm_q)));

  // R9
  static_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_rm == 3'b101 || inst_rm == 3'b110) |-> (rm_bad && eff_rm == inst_rm));

  // R9
  static_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_rm <= 3'b100) |-> (!rm_bad && eff_rm == inst_rm));

  // R10
  dyn_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_rm == 3'b111) |-> (eff_rm == rm_q && rm_bad == (rm_q >= 3'b101)));

  // R2
  flags_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h001) |-> (csr_rdata[XLEN-1:FLAG_W] == '0));

  // R5
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |-> (csr_rdata == '0));
endmodule

bind fpu_csr_unit fpu_csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_en    (csr_en),
  .csr_addr  (csr_addr),
  .csr_rdata (csr_rdata),
  .csr_hit   (csr_hit),
  .acc_valid (acc_valid),
  .acc_flags (acc_flags),
  .inst_rm   (inst_rm),
  .eff_rm    (eff_rm),
  .rm_bad    (rm_bad),
  .flags_q   (flags_q),
  .rm_q      (rm_q)
);

// File: tb/fpu_csr_unit_tb_top.sv
module fpu_csr_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_en;
  logic [1:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        csr_hit;
  logic        acc_valid;
  logic [4:0]  acc_flags;
  logic [2:0]  inst_rm;
  logic [2:0]  eff_rm;
  logic        rm_bad;

  int n_run  = 0;
  int n_fail = 0;

  logic [4:0] m_flags;
  logic [2:0] m_rm;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_csr_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_hit(csr_hit), .acc_valid(acc_valid), .acc_flags(acc_flags),
    .inst_rm(inst_rm), .eff_rm(eff_rm), .rm_bad(rm_bad)
  );

  function automatic logic [31:0] exp_rdata(logic [11:0] a);
    case (a)
      12'h001: return {27'd0, m_flags};
      12'h002: return {29'd0, m_rm};
      12'h003: return {24'd0, m_rm, m_flags};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(logic [11:0] a);
    case (a)
      12'h001: return "R2";
      12'h002: return "R3";
      12'h003: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [2:0] exp_eff(logic [2:0] f);
    return (f == 3'd7) ? m_rm : f;
  endfunction

  function automatic logic exp_bad(logic [2:0] f);
    logic [2:0] e;
    e = exp_eff(f);
    return (e == 3'd5) || (e == 3'd6) || (e == 3'd7);
  endfunction

  function automatic logic [2:0] op3(logic [1:0] op, logic [2:0] cur, logic [2:0] d);
    case (op)
      2'b01: return d;
      2'b10: return cur | d;
      2'b11: return cur & ~d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [4:0] op5(logic [1:0] op, logic [4:0] cur, logic [4:0] d);
    case (op)
      2'b01: return d;
      2'b10: return cur | d;
      2'b11: return cur & ~d;
      default: return cur;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, check combinational outputs, update the model after the rising edge.
  task automatic step(logic en, logic [1:0] op, logic [11:0] a, logic [31:0] wd,
                      logic av, logic [4:0] af, logic [2:0] irm);
    @(negedge clk);
    csr_en = en; csr_op = op; csr_addr = a; csr_wdata = wd;
    acc_valid = av; acc_flags = af; inst_rm = irm;
    #1;
    check(rd_tag(a), csr_rdata, exp_rdata(a));
    check((a >= 12'h001 && a <= 12'h003) ? "R11" : "R5", {31'd0, csr_hit},
          {31'd0, (a >= 12'h001 && a <= 12'h003)});
    check((irm == 3'd7) ? "R10" : "R9", {28'd0, rm_bad, eff_rm},
          {28'd0, exp_bad(irm), exp_eff(irm)});
    @(posedge clk);
    if (en && op != 2'b00) begin
      if (a == 12'h001 || a == 12'h003) m_flags = op5(op, m_flags, wd[4:0]);
      if (a == 12'h002) m_rm = op3(op, m_rm, wd[2:0]);
      if (a == 12'h003) m_rm = op3(op, m_rm, wd[7:5]);
    end
    if (av) m_flags = m_flags | af;
  endtask

  // Hand-computed expectation of {mode, flags} read through the combined address.
  task automatic expect_state(string tag, logic [7:0] e);
    @(negedge clk);
    csr_en = 1'b0; csr_op = 2'b00; csr_addr = 12'h003; acc_valid = 1'b0;
    #1;
    check(tag, csr_rdata, {24'd0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_en = 1'b0; csr_op = 2'b00; csr_addr = 12'h000;
    csr_wdata = '0; acc_valid = 1'b0; acc_flags = '0; inst_rm = 3'd0;
    m_flags = '0; m_rm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_state("R1", 8'h00);

    // R6: replace with upper bits ignored
    step(1, 2'b01, 12'h001, 32'hFFFF_FFFF, 0, 5'h00, 3'd0);
    expect_state("R6", 8'h1F);
    // R6: clear bits
    step(1, 2'b11, 12'h001, 32'h0000_0005, 0, 5'h00, 3'd1);
    expect_state("R6", 8'h1A);
    // R6: enable low ignored
    step(0, 2'b01, 12'h001, 32'h0000_0000, 0, 5'h00, 3'd2);
    expect_state("R6", 8'h1A);
    // R3/R6: mode write with upper bits ignored
    step(1, 2'b01, 12'h002, 32'hFFFF_FFF3, 0, 5'h00, 3'd7);
    expect_state("R3", 8'h7A);
    // R8: clear and raise in same cycle
    step(1, 2'b01, 12'h001, 32'h0000_0000, 1, 5'h04, 3'd3);
    expect_state("R8", 8'h64);
    // R7: accrual ORs in; invalid beat ignored
    step(0, 2'b00, 12'h000, 32'h0, 1, 5'h11, 3'd4);
    expect_state("R7", 8'h75);
    step(0, 2'b00, 12'h000, 32'h0, 0, 5'h1F, 3'd5);
    expect_state("R7", 8'h75);
    // R4: combined write, mode 111 stored
    step(1, 2'b01, 12'h003, 32'hFFFF_FFE2, 0, 5'h00, 3'd6);
    expect_state("R4", 8'hE2);
    // R10: dynamic with stored 111 is reserved
    step(0, 2'b00, 12'h002, 32'h0, 0, 5'h00, 3'd7);
    // R5: unmapped write has no effect
    step(1, 2'b01, 12'h004, 32'h0000_0000, 0, 5'h00, 3'd0);
    step(1, 2'b11, 12'h7FF, 32'hFFFF_FFFF, 0, 5'h00, 3'd0);
    expect_state("R5", 8'hE2);
    // R6: set through mode address
    step(1, 2'b11, 12'h002, 32'h0000_0006, 0, 5'h00, 3'd7);
    step(1, 2'b10, 12'h002, 32'h0000_0004, 0, 5'h00, 3'd7);
    expect_state("R6", 8'hA2);

    void'($urandom(32'd20250508));
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [11:0] a;
      logic [3:0]  pick;
      pick = 4'($urandom % 8);
      case (pick)
        4'd0: a = 12'h000;
        4'd1, 4'd2: a = 12'h001;
        4'd3, 4'd4: a = 12'h002;
        4'd5, 4'd6: a = 12'h003;
        default: a = 12'($urandom);
      endcase
      step(1'($urandom % 4 != 0), 2'($urandom), a, $urandom,
           1'($urandom % 3 == 0), 5'($urandom), 3'($urandom));
    end
    expect_state("R7", {m_rm, m_flags});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule